// File: doc/BRIEF.md
# Cluster DVFS Request Controller

This block accepts performance-level requests for two CPU clusters and one configuration-read request type over a plain 32-bit register bus. Each request starts a transition that takes a programmable number of clock cycles. The transition stands in for the slow regulator and clock change. When it ends, the block sets a completion flag or an error flag for that request type in one shared status word. It holds an interrupt line high for as long as any flag in that word is set.

Each cluster has a table of up to eight operating points and a count of how many of them are valid. A level request is judged against that count. Software finds the level by frequency and writes only the level index. Only one request can be outstanding at a time. A request that arrives while another is in flight is refused, and the refusal is reported as an error for the refused type.

The bus has no handshake. A write takes effect on the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`. `bus_rd` is a strobe that marks the read as consumed; it matters only at the status address.

Top module: `dvfs_ctrl`

## Requirements
- R1: After reset, both level registers read 0, status reads 0, `irq` is low, both valid-point counts read 0, and the delay register reads the `DELAY_RESET` parameter.
- R2: A write of level L to 0x00 (request type 0, first cluster) or to 0x08 (type 1, second cluster) is accepted when the block is idle and L is less than that cluster's valid count. Exactly D clock edges after the write edge, status bit 4·t (t is the type) becomes 1 and the level register reads L. Before that edge the level register still reads the old level.
- R3: A level write where L is greater than or equal to the cluster's valid count runs the same D-edge delay. It then sets status bit 4·t+1 instead of bit 4·t, and the level register keeps its old value.
- R4: A request write (0x00, 0x08, or 0x10 with bit 31 set) made while a request is outstanding is dropped. On the same edge, status bit 4·t+1 is set for the dropped request's type. The outstanding request completes unchanged.
- R5: Status is at 0x18, with bits 0/1 for type 0, bits 4/5 for type 1 and bits 8/9 for type 2. `irq` is high exactly when any of these bits is 1. A read with `bus_rd` at 0x18 clears all of them on that edge.
- R6: A write to 0x10 with bit 31 set is a type-2 request. Bit 3 picks the cluster and bits 2:0 pick the table entry. D edges later, status bit 8 is set and 0x14 reads that table entry. If bit 31 is clear, the write starts nothing.
- R7: The delay register at 0x28 sets D in clock edges. A value of 0 behaves as 1.
- R8: Table entries are read/write at 0x40 + 4·i (first cluster) and 0x60 + 4·i (second cluster). Valid counts are at 0x20 and 0x24 in bits 3:0. A count written above 8 saturates to 8.
- R9: When a flag is set on the same edge as a status read-clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one edge per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe; clears the status flags when addressing status |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Active-high level interrupt, high while any status flag is set |

## Verification
A request's outcome lands exactly D edges after its write edge, and a refusal lands on the write edge itself. The bench therefore samples the cycle counter on the falling edge after each write and queues the expected status word with its due cycle. A monitor checks, on each rising of `irq`, that the head item is due in that very cycle and that status matches. Level and table reads are made on falling edges mid-transition, to see the old level, and again after the due cycle. The read-clear race is provoked by strobing status in the one cycle where a one-cycle transition is finishing.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

  typedef enum logic [1:0] {
    REQ_CLU0 = 2'd0,
    REQ_CLU1 = 2'd1,
    REQ_CFG  = 2'd2
  } req_t;

  localparam int NUM_REQ = 3;

  localparam logic [7:0] OFF_LVL0  = 8'h00;
  localparam logic [7:0] OFF_LVL1  = 8'h08;
  localparam logic [7:0] OFF_CMD   = 8'h10;
  localparam logic [7:0] OFF_CDATA = 8'h14;
  localparam logic [7:0] OFF_STAT  = 8'h18;
  localparam logic [7:0] OFF_CNT0  = 8'h20;
  localparam logic [7:0] OFF_CNT1  = 8'h24;
  localparam logic [7:0] OFF_DLY   = 8'h28;
  localparam logic [7:0] OFF_TAB   = 8'h40;

  localparam int CMD_GO_BIT = 31;

endpackage

// File: rtl/dvfs_opp_table.sv
module dvfs_opp_table #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tab_we,
  input  logic              tab_wclu,
  input  logic [IDX_W-1:0]  tab_widx,
  input  logic [DATA_W-1:0] tab_wdata,
  input  logic [1:0]        cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              rd_clu,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cfg_clu,
  input  logic [IDX_W-1:0]  cfg_idx,
  output logic [DATA_W-1:0] cfg_data,
  output logic [CNT_W-1:0]  cnt0,
  output logic [CNT_W-1:0]  cnt1
);

  logic [DATA_W-1:0] ent   [2][DEPTH];
  logic [CNT_W-1:0]  cnt_q [2];
  logic [CNT_W-1:0]  cnt_sat;

  // counts above the table depth are saturated (R8)
  assign cnt_sat = (cnt_wdata > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : cnt_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        cnt_q[c] <= '0;
        for (int i = 0; i < DEPTH; i++) ent[c][i] <= '0;
      end
    end else begin
      if (tab_we) ent[tab_wclu][tab_widx] <= tab_wdata;
      for (int c = 0; c < 2; c++)
        if (cnt_we[c]) cnt_q[c] <= cnt_sat;
    end
  end

  assign rd_data  = ent[rd_clu][rd_idx];
  assign cfg_data = ent[cfg_clu][cfg_idx];
  assign cnt0     = cnt_q[0];
  assign cnt1     = cnt_q[1];

endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq
  import dvfs_pkg::*;
#(
  parameter int DELAY_W = 24,
  parameter int ARG_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  req_t               start_type,
  input  logic               start_bad,
  input  logic [ARG_W-1:0]   start_arg,
  input  logic [DELAY_W-1:0] delay,
  output logic               busy,
  output logic               fin,
  output req_t               fin_type,
  output logic               fin_bad,
  output logic [ARG_W-1:0]   fin_arg
);

  logic [DELAY_W-1:0] cnt_q;

  assign fin = busy && (cnt_q == DELAY_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt_q    <= '0;
      fin_type <= REQ_CLU0;
      fin_bad  <= 1'b0;
      fin_arg  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        cnt_q    <= (delay == '0) ? DELAY_W'(1) : delay;
        fin_type <= start_type;
        fin_bad  <= start_bad;
        fin_arg  <= start_arg;
      end
    end else if (fin) begin
      busy <= 1'b0;
    end else begin
      cnt_q <= cnt_q - DELAY_W'(1);
    end
  end

endmodule

// File: rtl/dvfs_status.sv
module dvfs_status #(
  parameter int NUM_T  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_T-1:0]  set_done,
  input  logic [NUM_T-1:0]  set_err,
  input  logic              clr,
  output logic [DATA_W-1:0] stat_word,
  output logic              any
);

  logic [NUM_T-1:0] done_q, err_q;

  for (genvar t = 0; t < NUM_T; t++) begin : g_type
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        done_q[t] <= 1'b0;
        err_q[t]  <= 1'b0;
      end else begin
        // a new event outranks a simultaneous read-clear
        if (set_done[t])  done_q[t] <= 1'b1;
        else if (clr)     done_q[t] <= 1'b0;
        if (set_err[t])   err_q[t]  <= 1'b1;
        else if (clr)     err_q[t]  <= 1'b0;
      end
    end
  end

  always_comb begin
    stat_word = '0;
    for (int t = 0; t < NUM_T; t++) begin
      stat_word[4*t]     = done_q[t];
      stat_word[4*t + 1] = err_q[t];
    end
  end

  assign any = |{done_q, err_q};

endmodule

// File: rtl/dvfs_ctrl.sv
module dvfs_ctrl
  import dvfs_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int OPP_DEPTH   = 8,
  parameter int DELAY_W     = 24,
  parameter int DELAY_RESET = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int IDX_W  = $clog2(OPP_DEPTH);
  localparam int CNT_W  = $clog2(OPP_DEPTH + 1);
  localparam int ARG_W  = IDX_W + 1;
  localparam int TAB_LG = IDX_W + 2;

  // address decode
  logic hit_lvl0, hit_lvl1, hit_cmd, hit_tab, tab_clu;
  logic [IDX_W-1:0] tab_idx;
  assign hit_lvl0 = bus_addr == ADDR_W'(OFF_LVL0);
  assign hit_lvl1 = bus_addr == ADDR_W'(OFF_LVL1);
  assign hit_cmd  = bus_addr == ADDR_W'(OFF_CMD);
  assign hit_tab  = (bus_addr >> (TAB_LG + 1)) == (ADDR_W'(OFF_TAB) >> (TAB_LG + 1));
  assign tab_clu  = bus_addr[TAB_LG];
  assign tab_idx  = bus_addr[TAB_LG-1:2];

  // table and counts
  logic [DATA_W-1:0] tab_rd, cfg_data;
  logic [CNT_W-1:0]  cnt0, cnt1;
  logic              seq_busy, seq_fin, fin_bad;
  req_t              fin_type;
  logic [ARG_W-1:0]  fin_arg;

  dvfs_opp_table #(.DATA_W(DATA_W), .DEPTH(OPP_DEPTH)) u_tab (
    .clk       (clk),
    .rst_n     (rst_n),
    .tab_we    (bus_wr && hit_tab),
    .tab_wclu  (tab_clu),
    .tab_widx  (tab_idx),
    .tab_wdata (bus_wdata),
    .cnt_we    ({bus_wr && bus_addr == ADDR_W'(OFF_CNT1),
                 bus_wr && bus_addr == ADDR_W'(OFF_CNT0)}),
    .cnt_wdata (bus_wdata[CNT_W-1:0]),
    .rd_clu    (tab_clu),
    .rd_idx    (tab_idx),
    .rd_data   (tab_rd),
    .cfg_clu   (fin_arg[ARG_W-1]),
    .cfg_idx   (fin_arg[IDX_W-1:0]),
    .cfg_data  (cfg_data),
    .cnt0      (cnt0),
    .cnt1      (cnt1)
  );

  // request capture
  logic             req_any, req_bad;
  req_t             req_type;
  logic [ARG_W-1:0] req_arg;

  always_comb begin
    req_any  = 1'b0;
    req_bad  = 1'b0;
    req_type = REQ_CLU0;
    req_arg  = '0;
    if (bus_wr && hit_lvl0) begin
      req_any = 1'b1;
      req_bad = bus_wdata >= DATA_W'(cnt0);
      req_arg = ARG_W'(bus_wdata[IDX_W-1:0]);
    end else if (bus_wr && hit_lvl1) begin
      req_any  = 1'b1;
      req_type = REQ_CLU1;
      req_bad  = bus_wdata >= DATA_W'(cnt1);
      req_arg  = ARG_W'(bus_wdata[IDX_W-1:0]);
    end else if (bus_wr && hit_cmd && bus_wdata[CMD_GO_BIT]) begin
      req_any  = 1'b1;
      req_type = REQ_CFG;
      req_arg  = bus_wdata[ARG_W-1:0];
    end
  end

  logic [DELAY_W-1:0] dly_q;

  dvfs_seq #(.DELAY_W(DELAY_W), .ARG_W(ARG_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (req_any),
    .start_type (req_type),
    .start_bad  (req_bad),
    .start_arg  (req_arg),
    .delay      (dly_q),
    .busy       (seq_busy),
    .fin        (seq_fin),
    .fin_type   (fin_type),
    .fin_bad    (fin_bad),
    .fin_arg    (fin_arg)
  );

  // status flags
  logic [NUM_REQ-1:0] set_done, set_err;
  logic [DATA_W-1:0]  stat_word;

  always_comb begin
    set_done = '0;
    set_err  = '0;
    if (seq_fin) begin
      if (fin_bad) set_err[fin_type]  = 1'b1;
      else         set_done[fin_type] = 1'b1;
    end
    if (req_any && seq_busy) set_err[req_type] = 1'b1;
  end

  dvfs_status #(.NUM_T(NUM_REQ), .DATA_W(DATA_W)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_done  (set_done),
    .set_err   (set_err),
    .clr       (bus_rd && bus_addr == ADDR_W'(OFF_STAT)),
    .stat_word (stat_word),
    .any       (irq)
  );

  // levels in effect, config read result, delay
  logic [IDX_W-1:0]  lvl_q [2];
  logic [DATA_W-1:0] cdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q[0] <= '0;
      lvl_q[1] <= '0;
      cdata_q  <= '0;
      dly_q    <= DELAY_W'(DELAY_RESET);
    end else begin
      if (seq_fin && !fin_bad) begin
        if (fin_type == REQ_CFG) cdata_q <= cfg_data;
        else lvl_q[fin_type == REQ_CLU1] <= fin_arg[IDX_W-1:0];
      end
      if (bus_wr && bus_addr == ADDR_W'(OFF_DLY)) dly_q <= bus_wdata[DELAY_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_tab) bus_rdata = tab_rd;
    else begin
      case (bus_addr)
        ADDR_W'(OFF_LVL0):  bus_rdata = DATA_W'(lvl_q[0]);
        ADDR_W'(OFF_LVL1):  bus_rdata = DATA_W'(lvl_q[1]);
        ADDR_W'(OFF_CDATA): bus_rdata = cdata_q;
        ADDR_W'(OFF_STAT):  bus_rdata = stat_word;
        ADDR_W'(OFF_CNT0):  bus_rdata = DATA_W'(cnt0);
        ADDR_W'(OFF_CNT1):  bus_rdata = DATA_W'(cnt1);
        ADDR_W'(OFF_DLY):   bus_rdata = DATA_W'(dly_q);
        default:            bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/dvfs_ctrl_chk.sv
module dvfs_ctrl_chk
  import dvfs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LVL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              irq,
  input logic              busy,
  input logic              fin,
  input logic              fin_bad,
  input req_t              fin_type,
  input logic [LVL_W-1:0]  lvl0,
  input logic [LVL_W-1:0]  lvl1
);

  a_r2_level0_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(fin && !fin_bad && fin_type == REQ_CLU0) |=> $stable(lvl0));

  a_r3_error_keeps_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && fin_bad) |=> ($stable(lvl0) && $stable(lvl1)));

  a_r4_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> busy);

  a_r5_result_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> irq);

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(OFF_STAT) && !fin && !bus_wr) |=> !irq);

endmodule

bind dvfs_ctrl dvfs_ctrl_chk #(.ADDR_W(ADDR_W), .LVL_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .irq      (irq),
  .busy     (seq_busy),
  .fin      (seq_fin),
  .fin_bad  (fin_bad),
  .fin_type (fin_type),
  .lvl0     (lvl_q[0]),
  .lvl1     (lvl_q[1])
);

// File: tb/tb_dvfs_ctrl.sv
`timescale 1ns/1ps
module tb_dvfs_ctrl;
  import dvfs_pkg::*;

  localparam int D = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = OFF_STAT;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;

  always #2 clk = ~clk;

  dvfs_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_tests = 0;
  int n_fail = 0;
  bit done_flag = 0;

  typedef struct packed { int due; logic [31:0] stat; } exp_t;
  exp_t sb[$];

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = OFF_STAT;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = OFF_STAT;
  endtask

  task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic push(input int due, input logic [31:0] s);
    sb.push_back(exp_t'{due: due, stat: s});
  endtask

  // scoreboard monitor: each irq rise must match the head item's due cycle and status
  initial begin
    logic prev;
    exp_t e;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && irq && !prev) begin
        if (sb.size() == 0) begin
          n_tests++; n_fail++;
          $display("FAIL R5 irq without pending item: got 1 expected 0 at cycle %0d", cyc);
        end else begin
          e = sb.pop_front();
          chk("R2/R3/R4/R6 result cycle", 32'(cyc), 32'(e.due));
          if (bus_addr == OFF_STAT) chk("R5 status at irq", bus_rdata, e.stat);
        end
      end
      prev = irq;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int c0;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    rchk("R1 level0", OFF_LVL0, 0);
    rchk("R1 level1", OFF_LVL1, 0);
    rchk("R1 status", OFF_STAT, 0);
    rchk("R1 count0", OFF_CNT0, 0);
    rchk("R1 delay", OFF_DLY, 20);

    // R8 table and counts
    wr(OFF_CNT0, 5);
    wr(OFF_CNT1, 15);
    rchk("R8 count0", OFF_CNT0, 5);
    rchk("R8 count1 saturates", OFF_CNT1, 8);
    wr(8'h54, 32'hCAFE0005);
    wr(8'h68, 32'h0B0B0002);
    rchk("R8 table0[5]", 8'h54, 32'hCAFE0005);
    rchk("R8 table1[2]", 8'h68, 32'h0B0B0002);
    wr(OFF_DLY, D);
    rchk("R7 delay readback", OFF_DLY, D);

    // R2 cluster 0 success
    wr(OFF_LVL0, 3);
    push(cyc + D, 32'h1);
    rchk("R2 level0 old during transition", OFF_LVL0, 0);
    repeat (D + 1) @(negedge clk);
    rchk("R5 status done0", OFF_STAT, 32'h1);
    chk("R5 irq low after read", 32'(irq), 0);
    rchk("R2 level0 new", OFF_LVL0, 3);

    // R2 cluster 1 success
    wr(OFF_LVL1, 7);
    push(cyc + D, 32'h10);
    repeat (D + 1) @(negedge clk);
    rchk("R2 status done1", OFF_STAT, 32'h10);
    rchk("R2 level1 new", OFF_LVL1, 7);

    // R3 invalid levels
    wr(OFF_LVL0, 5);
    push(cyc + D, 32'h2);
    repeat (D + 1) @(negedge clk);
    rchk("R3 status err0", OFF_STAT, 32'h2);
    rchk("R3 level0 kept", OFF_LVL0, 3);
    wr(OFF_LVL1, 9);
    push(cyc + D, 32'h20);
    repeat (D + 1) @(negedge clk);
    rchk("R3 status err1", OFF_STAT, 32'h20);
    rchk("R3 level1 kept", OFF_LVL1, 7);

    // R4 refusal while busy
    wr(OFF_LVL0, 1);
    c0 = cyc;
    wr(OFF_LVL1, 2);
    push(cyc, 32'h20);
    push(c0 + D, 32'h1);
    rchk("R4 refusal flag", OFF_STAT, 32'h20);
    repeat (D) @(negedge clk);
    rchk("R4 outstanding completes", OFF_STAT, 32'h1);
    rchk("R4 level1 untouched", OFF_LVL1, 7);
    rchk("R4 level0 applied", OFF_LVL0, 1);

    // R6 configuration reads
    wr(OFF_CMD, 32'h8000_0005);
    push(cyc + D, 32'h100);
    repeat (D + 1) @(negedge clk);
    rchk("R6 status cfg done", OFF_STAT, 32'h100);
    rchk("R6 data table0[5]", OFF_CDATA, 32'hCAFE0005);
    wr(OFF_CMD, 32'h8000_000A);
    push(cyc + D, 32'h100);
    repeat (D + 1) @(negedge clk);
    rchk("R6 status cfg done 2", OFF_STAT, 32'h100);
    rchk("R6 data table1[2]", OFF_CDATA, 32'h0B0B0002);
    wr(OFF_CMD, 32'h0000_0005);
    repeat (D + 2) @(negedge clk);
    chk("R6 no-go irq", 32'(irq), 0);
    rchk("R6 no-go status", OFF_STAT, 0);
    rchk("R6 no-go data kept", OFF_CDATA, 32'h0B0B0002);

    // R7 zero delay acts as one
    wr(OFF_DLY, 0);
    wr(OFF_LVL0, 2);
    push(cyc + 1, 32'h1);
    repeat (2) @(negedge clk);
    rchk("R7 status after one edge", OFF_STAT, 32'h1);
    rchk("R7 level0", OFF_LVL0, 2);

    // R9 set wins over read-clear on the same edge
    wr(OFF_LVL0, 4);
    push(cyc + 1, 32'h1);
    bus_addr = OFF_STAT; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R9 read before set", v, 0);
    #2;
    chk("R9 flag survives clear", bus_rdata, 32'h1);
    rchk("R9 status then cleared", OFF_STAT, 32'h1);
    chk("R9 irq low", 32'(irq), 0);

    repeat (2) @(negedge clk);
    chk("scoreboard drained", 32'(sb.size()), 0);

    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule